// File: doc/BRIEF.md
# Scan-Port Memory Bridge

This block adds a bus master to a four-wire test access port. A debug host driving TCK, TMS and TDI (and reading TDO) chooses one of a handful of user instructions. With them it loads a 16-bit bus address and then moves single bytes to or from a memory on a Wishbone classic bus. The bus lives in an independent system clock domain.

Each byte pass through the data path starts with a bus read at the current address. The byte read back is the one shifted out. Under the read-only instruction nothing is written. Under the read-write instruction the shifted-in byte is written back to the same address when the pass ends. After every byte pass the address moves up by one, so a stream of byte passes walks through memory without reloading the address.

A small user shift register and the usual one-bit bypass path complete the data-register set.

Instruction codes, shifted least significant bit first:

| Code | Function |
|------|----------|
| 011 | user register |
| 100 | address register |
| 101 | memory read |
| 110 | memory read-write |
| any other code | bypass |

Requests cross from the TCK domain into the system domain as a toggle through a synchronizer chain. The host must run TCK at no more than one sixteenth of the system clock rate.

Top module: `jwb_bridge`

## Requirements
- R1: The TAP controller follows the standard sixteen-state graph. Five rising TCK edges with TMS high reach Test-Logic-Reset from any state, and that state forces the instruction to bypass (111) without changing the address register.
- R2: The instruction register is 3 bits wide and shifts least significant bit first. Capture-IR loads 001, and the new instruction takes effect at Update-IR.
- R3: Every code other than 011, 100, 101 and 110 selects a 1-bit bypass register. It captures 0 and returns each TDI bit one shift later.
- R4: Code 011 selects a 3-bit user register. Each pass shifts out the value loaded by the previous pass.
- R5: Code 100 selects the 16-bit address register. A pass shifts out the current address and loads the shifted-in value at Update-DR.
- R6: Code 101: leaving Select-DR-Scan towards Capture-DR issues a bus read (WE low) at the current address. The returned byte is shifted out least significant bit first, and no bus write follows.
- R7: Code 110 shifts out the byte stored at the current address. At Update-DR it writes the shifted-in byte to that same address, with WE high and every SEL bit set.
- R8: Every Update-DR under code 101 or 110 adds one to the address register, which wraps from FFFF to 0000.
- R9: CYC and STB rise together and stay high, with address, WE and write data unchanged, until ACK. Both fall on the clock after ACK.
- R10: TDO changes only on falling TCK edges and is low whenever the controller is in neither shift state.
- R11: An active-low TRST_N puts the controller in Test-Logic-Reset, the instruction at bypass, and the address and user registers at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| clk | input | 1 | System clock for the bus side |
| rst | input | 1 | Synchronous bus-side reset, active high |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_sel | output | DATA_W/8 | Byte selects, all set during a transfer |
| wb_adr | output | ADDR_W | Byte address |
| wb_dat_w | output | DATA_W | Write data |
| wb_dat_r | input | DATA_W | Read data |
| wb_ack | input | 1 | Transfer acknowledge |

## Verification
Serial results are due at fixed TCK edges. The first bit of a data or instruction pass appears on TDO at the falling edge after the capture edge, so the bench reads TDO just before each rising edge. It also checks, one step after the capture edge, that TDO has not moved yet. Instruction and register updates take effect at the rising edge that leaves the Update state. Bus reads must complete within the single TCK period between the Select-DR-Scan edge and the capture edge, and writes within the period after Update-DR. The bench therefore runs TCK at sixteen system clocks and inspects the recorded bus transfers only after the pass has returned to Run-Test/Idle.

// File: rtl/jwb_pkg.sv
package jwb_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
   } tap_state_e;

   localparam int unsigned OP_W = 3;
   localparam logic [OP_W-1:0] OP_USER   = 3'b011;
   localparam logic [OP_W-1:0] OP_ADDR   = 3'b100;
   localparam logic [OP_W-1:0] OP_MEMRD  = 3'b101;
   localparam logic [OP_W-1:0] OP_MEMRW  = 3'b110;
   localparam logic [OP_W-1:0] OP_BYPASS = 3'b111;
   localparam logic [OP_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/jwb_tap_fsm.sv
module jwb_tap_fsm
   import jwb_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      case (state)
         TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
         TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
         TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
         TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
         TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
         TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
         TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
         TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
         TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
         TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
         TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
         TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
         TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
         TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
         TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
         TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
         default:     nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_RESET;
      else         state <= nxt;
   end

   AST_TLR_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET && tms) |=> (state == TS_RESET)); // R1

   AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_SHIFT_DR) |-> ($past(state) == TS_CAP_DR || $past(state) == TS_SHIFT_DR
                                  || $past(state) == TS_EXIT2_DR)); // R1

endmodule

// File: rtl/jwb_sync.sv
module jwb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("jwb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/jwb_bus_master.sv
module jwb_bus_master #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_tgl,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_adr,
   input  logic [DATA_W-1:0] req_wdat,
   output logic              wb_cyc,
   output logic              wb_stb,
   output logic              wb_we,
   output logic [SEL_W-1:0]  wb_sel,
   output logic [ADDR_W-1:0] wb_adr,
   output logic [DATA_W-1:0] wb_dat_w,
   input  logic [DATA_W-1:0] wb_dat_r,
   input  logic              wb_ack,
   output logic [DATA_W-1:0] rd_dat
);

   logic tgl_s;
   logic tgl_seen;
   logic start;

   jwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk (clk),
      .rst (rst),
      .d   (req_tgl),
      .q   (tgl_s)
   );

   assign start = (tgl_s != tgl_seen);

   always_ff @(posedge clk) begin
      if (rst) begin
         tgl_seen <= 1'b0;
         wb_cyc   <= 1'b0;
         wb_stb   <= 1'b0;
         wb_we    <= 1'b0;
         wb_adr   <= '0;
         wb_dat_w <= '0;
         rd_dat   <= '0;
      end else if (!wb_cyc && start) begin
         tgl_seen <= tgl_s;
         wb_cyc   <= 1'b1;
         wb_stb   <= 1'b1;
         wb_we    <= req_we;
         wb_adr   <= req_adr;
         wb_dat_w <= req_wdat;
      end else if (wb_cyc && wb_ack) begin
         wb_cyc <= 1'b0;
         wb_stb <= 1'b0;
         wb_we  <= 1'b0;
         if (!wb_we) rd_dat <= wb_dat_r;
      end
   end

   assign wb_sel = {SEL_W{wb_stb}};

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
      (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w))); // R9

   AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
      (wb_stb && wb_ack) |=> (!wb_stb && !wb_cyc)); // R9

   AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (rst)
      wb_stb |-> wb_cyc); // R9

endmodule

// File: rtl/jwb_bridge.sv
module jwb_bridge
   import jwb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned USER_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = DATA_W / 8
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   input  logic              clk,
   input  logic              rst,
   output logic              wb_cyc,
   output logic              wb_stb,
   output logic              wb_we,
   output logic [SEL_W-1:0]  wb_sel,
   output logic [ADDR_W-1:0] wb_adr,
   output logic [DATA_W-1:0] wb_dat_w,
   input  logic [DATA_W-1:0] wb_dat_r,
   input  logic              wb_ack
);

   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("jwb_bridge: DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("jwb_bridge: ADDR_W must be at least 1");
   end
   if (USER_W < 1) begin : g_bad_user_w
      $error("jwb_bridge: USER_W must be at least 1");
   end

   tap_state_e state;

   logic [OP_W-1:0]   ir_q, ir_sr;
   logic              byp_q;
   logic [USER_W-1:0] user_q, user_sr;
   logic [ADDR_W-1:0] addr_q, addr_sr;
   logic [DATA_W-1:0] dat_sr;
   logic              req_tgl, req_we;
   logic [ADDR_W-1:0] req_adr;
   logic [DATA_W-1:0] req_wdat;
   logic [DATA_W-1:0] rd_dat;
   logic              tdo_q;

   logic sel_user, sel_addr, sel_rd, sel_rw, is_mem;
   logic dr_lsb;

   logic [USER_W:0] user_cat;
   logic [ADDR_W:0] addr_cat;
   logic [DATA_W:0] dat_cat;
   logic [OP_W:0]   ir_cat;

   jwb_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   assign sel_user = (ir_q == OP_USER);
   assign sel_addr = (ir_q == OP_ADDR);
   assign sel_rd   = (ir_q == OP_MEMRD);
   assign sel_rw   = (ir_q == OP_MEMRW);
   assign is_mem   = sel_rd | sel_rw;

   assign user_cat = {tdi, user_sr};
   assign addr_cat = {tdi, addr_sr};
   assign dat_cat  = {tdi, dat_sr};
   assign ir_cat   = {tdi, ir_sr};

   always_comb begin
      if (sel_user)      dr_lsb = user_sr[0];
      else if (sel_addr) dr_lsb = addr_sr[0];
      else if (is_mem)   dr_lsb = dat_sr[0];
      else               dr_lsb = byp_q;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_q     <= OP_BYPASS;
         ir_sr    <= '0;
         byp_q    <= 1'b0;
         user_q   <= '0;
         user_sr  <= '0;
         addr_q   <= '0;
         addr_sr  <= '0;
         dat_sr   <= '0;
         req_tgl  <= 1'b0;
         req_we   <= 1'b0;
         req_adr  <= '0;
         req_wdat <= '0;
      end else begin
         case (state)
            TS_RESET:    ir_q  <= OP_BYPASS;
            TS_CAP_IR:   ir_sr <= IR_CAPTURE;
            TS_SHIFT_IR: ir_sr <= ir_cat[OP_W:1];
            TS_UPD_IR:   ir_q  <= ir_sr;
            TS_SEL_DR: begin
               if (!tms && is_mem) begin
                  req_tgl <= ~req_tgl;
                  req_we  <= 1'b0;
                  req_adr <= addr_q;
               end
            end
            TS_CAP_DR: begin
               byp_q   <= 1'b0;
               user_sr <= user_q;
               addr_sr <= addr_q;
               dat_sr  <= rd_dat;
            end
            TS_SHIFT_DR: begin
               byp_q   <= tdi;
               user_sr <= user_cat[USER_W:1];
               addr_sr <= addr_cat[ADDR_W:1];
               dat_sr  <= dat_cat[DATA_W:1];
            end
            TS_UPD_DR: begin
               if (sel_user) user_q <= user_sr;
               if (sel_addr) addr_q <= addr_sr;
               if (is_mem)   addr_q <= addr_q + 1'b1;
               if (sel_rw) begin
                  req_tgl  <= ~req_tgl;
                  req_we   <= 1'b1;
                  req_adr  <= addr_q;
                  req_wdat <= dat_sr;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                   tdo_q <= 1'b0;
      else if (state == TS_SHIFT_IR) tdo_q <= ir_sr[0];
      else if (state == TS_SHIFT_DR) tdo_q <= dr_lsb;
      else                           tdo_q <= 1'b0;
   end

   assign tdo = tdo_q;

   jwb_bus_master #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_master (
      .clk      (clk),
      .rst      (rst),
      .req_tgl  (req_tgl),
      .req_we   (req_we),
      .req_adr  (req_adr),
      .req_wdat (req_wdat),
      .wb_cyc   (wb_cyc),
      .wb_stb   (wb_stb),
      .wb_we    (wb_we),
      .wb_sel   (wb_sel),
      .wb_adr   (wb_adr),
      .wb_dat_w (wb_dat_w),
      .wb_dat_r (wb_dat_r),
      .wb_ack   (wb_ack),
      .rd_dat   (rd_dat)
   );

   AST_TLR_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET) |=> (ir_q == OP_BYPASS)); // R1

   AST_ADDR_STEP: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_UPD_DR && is_mem) |=> (addr_q == $past(addr_q) + 1'b1)); // R8

   AST_NO_WRITE_ON_READ: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_UPD_DR && sel_rd) |=> $stable(req_tgl)); // R6

   AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      (state != TS_SHIFT_DR && state != TS_SHIFT_IR) |-> !tdo); // R10

endmodule

// File: tb/jwb_bridge_tb.sv
`timescale 1ns/1ps
module jwb_bridge_tb;

   localparam int CLK_HALF = 4;   // 125 MHz
   localparam int TCK_HALF = 64;  // TCK = clk / 16

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic clk = 1'b0, rst = 1'b1;
   logic tdo;
   logic wb_cyc, wb_stb, wb_we, wb_ack;
   logic [0:0]  wb_sel;
   logic [15:0] wb_adr;
   logic [7:0]  wb_dat_w, wb_dat_r;

   int checks = 0, errors = 0;
   logic tdo_rise;

   logic [7:0]  mem [256];
   logic [7:0]  shadow [256];
   int          wr_count = 0, rd_count = 0, stb_no_cyc = 0, bad_sel = 0;
   logic [15:0] last_wr_adr = '0, last_rd_adr = '0;
   logic [7:0]  last_wr_dat = '0;

   always #(CLK_HALF) clk = ~clk;

   jwb_bridge u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .clk(clk), .rst(rst),
      .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
      .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
   );

   // Byte-wide memory model, acknowledges one clock after the strobe.
   initial begin
      wb_ack = 1'b0;
      wb_dat_r = '0;
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 8'((i * 29 + 17) & 8'hFF);
         shadow[i] = 8'((i * 29 + 17) & 8'hFF);
      end
   end

   always @(posedge clk) begin
      if (wb_stb && !wb_cyc) stb_no_cyc <= stb_no_cyc + 1;
      if (wb_stb && wb_sel != 1'b1) bad_sel <= bad_sel + 1;
      if (wb_cyc && wb_stb && wb_ack) begin
         if (wb_we) begin
            wr_count    <= wr_count + 1;
            last_wr_adr <= wb_adr;
            last_wr_dat <= wb_dat_w;
         end else begin
            rd_count    <= rd_count + 1;
            last_rd_adr <= wb_adr;
         end
      end
      wb_ack <= wb_cyc && wb_stb && !wb_ack;
      if (wb_cyc && wb_stb && !wb_ack) begin
         if (wb_we) mem[wb_adr[7:0]] <= wb_dat_w;
         wb_dat_r <= mem[wb_adr[7:0]];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tck_cycle(input logic tms_v, input logic tdi_v, output logic tdo_v);
      tms = tms_v;
      tdi = tdi_v;
      #(TCK_HALF);
      tdo_v = tdo;
      tck = 1'b1;
      #1;
      tdo_rise = tdo;
      #(TCK_HALF - 1);
      tck = 1'b0;
   endtask

   task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
      logic d;
      tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
      for (int i = 0; i < 3; i++) begin
         tck_cycle(i == 2, op[i], d);
         cap[i] = d;
      end
      tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
   endtask

   task automatic shift_dr(input int n, input logic [15:0] din, output logic [15:0] dout,
                           output logic rise_after_cap);
      logic d;
      dout = '0;
      tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
      rise_after_cap = tdo_rise;
      for (int i = 0; i < n; i++) begin
         tck_cycle(i == n - 1, din[i], d);
         dout[i] = d;
      end
      tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
   endtask

   // Watchdog: a hung run counts as a failed check.
   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [2:0]  cap;
      logic [15:0] out;
      logic        rise;
      logic [2:0]  prev;
      logic [15:0] a;
      logic [7:0]  nb;
      logic        d;

      #100;
      chk("R10 tdo low in reset", {31'b0, tdo}, 32'd0);
      chk("R9 bus idle in reset", {31'b0, wb_cyc}, 32'd0);
      trst_n = 1'b1;
      rst    = 1'b0;
      #50;
      tck_cycle(1'b0, 1'b0, d);   // Test-Logic-Reset -> Run-Test/Idle
      chk("R10 tdo low in idle", {31'b0, tdo}, 32'd0);

      // R4 user register: each pass returns the previous load
      load_ir(3'b011, cap);
      chk("R2 capture pattern", {29'b0, cap}, 32'h1);
      prev = 3'b000;
      for (int v = 0; v < 8; v++) begin
         shift_dr(3, 16'(v), out, rise);
         chk("R4 user register previous value", {29'b0, out[2:0]}, {29'b0, prev});
         prev = 3'(v);
      end

      // R3 bypass for every unassigned code
      for (int k = 0; k < 4; k++) begin
         logic [2:0] op;
         op = (k == 3) ? 3'b111 : 3'(k);
         load_ir(op, cap);
         chk("R2 capture pattern", {29'b0, cap}, 32'h1);
         shift_dr(4, 16'hD, out, rise);
         chk("R3 bypass delays by one", {28'b0, out[3:0]}, 32'h1A & 32'hF);
      end

      // R5 / R11 address register
      load_ir(3'b100, cap);
      shift_dr(16, 16'hFFFC, out, rise);
      chk("R11 address reset value", {16'b0, out}, 32'h0);
      shift_dr(16, 16'hFFFC, out, rise);
      chk("R5 address readback", {16'b0, out}, 32'hFFFC);

      // R7 read-write walking across the wrap
      load_ir(3'b110, cap);
      for (int k = 0; k < 6; k++) begin
         a  = 16'hFFFC + 16'(k);
         nb = 8'((k * 53 + 10) & 8'hFF);
         shift_dr(8, {8'b0, nb}, out, rise);
         chk("R7 old byte shifted out", {24'b0, out[7:0]}, {24'b0, shadow[a[7:0]]});
         chk("R10 tdo waits for falling edge", {31'b0, rise}, 32'd0);
         shadow[a[7:0]] = nb;
         chk("R7 write address", {16'b0, last_wr_adr}, {16'b0, a});
         chk("R7 write data", {24'b0, last_wr_dat}, {24'b0, nb});
         chk("R7 write count", 32'(wr_count), 32'(k + 1));
         chk("R6 read address before write", {16'b0, last_rd_adr}, {16'b0, a});
      end

      // R8 address advanced by six with wrap
      load_ir(3'b100, cap);
      shift_dr(16, 16'hFFFC, out, rise);
      chk("R8 address after six passes", {16'b0, out}, 32'h0002);

      // R6 read-only passes
      load_ir(3'b101, cap);
      for (int k = 0; k < 6; k++) begin
         a = 16'hFFFC + 16'(k);
         shift_dr(8, 16'h00FF, out, rise);
         chk("R6 byte read", {24'b0, out[7:0]}, {24'b0, shadow[a[7:0]]});
         chk("R6 read address", {16'b0, last_rd_adr}, {16'b0, a});
      end
      chk("R6 no write under read", 32'(wr_count), 32'd6);
      chk("R6 memory untouched", {24'b0, mem[8'hFC]}, {24'b0, shadow[8'hFC]});

      load_ir(3'b100, cap);
      shift_dr(16, 16'h1234, out, rise);
      chk("R8 address after read passes", {16'b0, out}, 32'h0002);

      // R1 return to Test-Logic-Reset through TMS
      for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, d);
      tck_cycle(1'b0, 1'b0, d);
      shift_dr(4, 16'h6, out, rise);
      chk("R1 reset selects bypass", {28'b0, out[3:0]}, 32'hC);
      load_ir(3'b100, cap);
      shift_dr(16, 16'h0000, out, rise);
      chk("R1 address kept over TMS reset", {16'b0, out}, 32'h1234);

      chk("R9 strobe only inside cycle", 32'(stb_no_cyc), 32'd0);
      chk("R7 select bits set", 32'(bad_sel), 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule